// File: doc/BRIEF.md
# Two-Pin Edge Capture Register

This block watches two asynchronous event pins and keeps one 8-bit control and status register for them. Each pin has three bits: a polarity choice that selects rising or falling edges, a sticky capture flag, and an interrupt enable. Software polls the capture flags, or lets the interrupt outputs fire. A captured edge stays recorded until software clears it.

Each pin passes through a two-flop synchronizer and then an edge detector. When a qualifying edge appears, the pin's capture flag is set. Software clears a flag by writing 0 to it. Writing 1 to a flag leaves it as it is. Each pin's interrupt output is its flag ANDed with its enable.

Top module: `edge_latch_reg`

## Requirements
- R1: After reset the register reads 8'h00 and both interrupt outputs are low.
- R2: Bits 7 and 6 always read 0, whatever was written to them.
- R3: With a pin's polarity bit at 0, a falling edge on the pin sets its capture flag, and a rising edge does not.
- R4: With a pin's polarity bit at 1, a rising edge on the pin sets its capture flag, and a falling edge does not.
- R5: A set capture flag stays set with no further pin activity. Writing 1 to the flag's bit also leaves it set.
- R6: Writing 0 to a capture flag bit clears the flag.
- R7: If a qualifying edge and a clearing write reach a flag in the same cycle, the flag ends up set.
- R8: Each interrupt output equals that pin's capture flag AND its enable bit.
- R9: An edge on one pin never changes the other pin's capture flag.
- R10: Suppose a pin changes between two clock edges. Its capture flag still reads 0 after two rising clock edges and reads its new value after the third.
- R11: The bit layout from bit 5 down to bit 0 is: pin B polarity, pin B flag, pin B enable, pin A polarity, pin A flag, pin A enable. Polarity and enable bits read back exactly as written. rdata shows the register while sel is high and reads 0 while sel is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Register select |
| wr_en | input | 1 | Write strobe; a write takes effect when sel is also high |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| pin_a | input | 1 | Asynchronous event pin A |
| pin_b | input | 1 | Asynchronous event pin B |
| irq_a | output | 1 | Interrupt for pin A |
| irq_b | output | 1 | Interrupt for pin B |

## Verification
The hardest case to reach is the collision in R7. A detected edge and a clearing write must land on the same clock edge. The detected edge only exists inside the synchronizer, three register stages after the pin moves. The bench counts clock edges from the pin change and raises the write strobe in the half cycle just before the third edge. It then repeats the write one cycle later to show the ordinary clear path. The rest of the bench sweeps all 256 write values and every combination of pin, polarity, enable and edge direction.

// File: rtl/edge_latch_pkg.sv
package edge_latch_pkg;
  localparam int NUM_PINS   = 2;
  localparam int FIELD_W    = 3;
  localparam int REG_W      = 8;
  localparam int OFF_EN     = 0;
  localparam int OFF_FLAG   = 1;
  localparam int OFF_POL    = 2;

  // Detected edge for the selected polarity: 1 = rising, 0 = falling
  function automatic logic edge_match(input logic pol, input logic prev, input logic cur);
    return pol ? (cur & ~prev) : (prev & ~cur);
  endfunction

  // Next value of a sticky flag
  function automatic logic flag_next(input logic flag, input logic hit,
                                     input logic wr, input logic wbit);
    logic kept;
    kept = wr ? (flag & wbit) : flag;
    return kept | hit;
  endfunction

  function automatic logic [FIELD_W-1:0] pack_field(input logic pol, input logic flag,
                                                    input logic en);
    logic [FIELD_W-1:0] f;
    f = '0;
    f[OFF_POL]  = pol;
    f[OFF_FLAG] = flag;
    f[OFF_EN]   = en;
    return f;
  endfunction
endpackage

// File: rtl/elr_sync.sv
module elr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/elr_chan.sv
module elr_chan
  import edge_latch_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pin,
  input  logic               wr_hit,
  input  logic [FIELD_W-1:0] wfield,
  output logic               edge_hit,
  output logic               flag_q,
  output logic               en_q,
  output logic               pol_q
);
  logic pin_s;
  logic pin_prev;

  elr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin),
    .q    (pin_s)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pin_prev <= 1'b0;
    else        pin_prev <= pin_s;
  end

  assign edge_hit = edge_match(pol_q, pin_prev, pin_s);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      en_q   <= 1'b0;
      pol_q  <= 1'b0;
    end else begin
      flag_q <= flag_next(flag_q, edge_hit, wr_hit, wfield[OFF_FLAG]);
      if (wr_hit) begin
        en_q  <= wfield[OFF_EN];
        pol_q <= wfield[OFF_POL];
      end
    end
  end
endmodule

// File: rtl/edge_latch_reg.sv
module edge_latch_reg
  import edge_latch_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic             pin_a,
  input  logic             pin_b,
  output logic             irq_a,
  output logic             irq_b
);
  localparam int USED_W = NUM_PINS * FIELD_W;

  logic                wr_hit;
  logic [NUM_PINS-1:0] pins;
  logic [NUM_PINS-1:0] edge_hit;
  logic [NUM_PINS-1:0] flag_q;
  logic [NUM_PINS-1:0] en_q;
  logic [NUM_PINS-1:0] pol_q;
  logic [USED_W-1:0]   fields;
  logic                unused_hi;

  assign wr_hit    = sel & wr_en;
  assign pins      = {pin_b, pin_a};
  assign unused_hi = ^wdata[REG_W-1:USED_W];

  for (genvar c = 0; c < NUM_PINS; c++) begin : g_chan
    elr_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin     (pins[c]),
      .wr_hit  (wr_hit),
      .wfield  (wdata[c*FIELD_W +: FIELD_W]),
      .edge_hit(edge_hit[c]),
      .flag_q  (flag_q[c]),
      .en_q    (en_q[c]),
      .pol_q   (pol_q[c])
    );
    assign fields[c*FIELD_W +: FIELD_W] = pack_field(pol_q[c], flag_q[c], en_q[c]);
  end

  assign rdata = sel ? {{(REG_W-USED_W){1'b0}}, fields} : '0;
  assign irq_a = flag_q[0] & en_q[0];
  assign irq_b = flag_q[1] & en_q[1];
endmodule

// File: rtl/edge_latch_reg_checker.sv
module edge_latch_reg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       irq_a,
  input logic       irq_b,
  input logic       wr_hit,
  input logic [1:0] edge_hit,
  input logic [1:0] flag_q
);
  logic [1:0] irq_v;
  assign irq_v = {irq_b, irq_a};

  assert_top_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[7:6] == 2'b00);

  for (genvar i = 0; i < 2; i++) begin : g_chk
    assert_edge_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit[i] |=> flag_q[i]);
    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !(wr_hit && !wdata[3*i+1])) |=> flag_q[i]);
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !wdata[3*i+1] && !edge_hit[i]) |=> !flag_q[i]);
    assert_only_edge_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q[i] && !edge_hit[i]) |=> !flag_q[i]);
    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_v[i]) |-> $past(edge_hit[i] || wr_hit));
  end
endmodule

bind edge_latch_reg edge_latch_reg_checker u_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .wdata   (wdata),
  .rdata   (rdata),
  .irq_a   (irq_a),
  .irq_b   (irq_b),
  .wr_hit  (wr_hit),
  .edge_hit(edge_hit),
  .flag_q  (flag_q)
);

// File: tb/edge_latch_reg_test.sv
module edge_latch_reg_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       pin_a = 1'b0;
  logic       pin_b = 1'b0;
  logic       irq_a;
  logic       irq_b;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  edge_latch_reg uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .pin_a(pin_a), .pin_b(pin_b), .irq_a(irq_a), .irq_b(irq_b)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wr_en = 1'b1; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_pin(input int c, input logic v);
    if (c == 0) pin_a = v; else pin_b = v;
  endtask

  function automatic logic [7:0] cfg_of(input int c, input logic pol, input logic en);
    return 8'((pol << (3*c+2)) | (en << (3*c)));
  endfunction

  function automatic logic [7:0] flag_bit(input int c);
    return 8'(1 << (3*c+1));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    sel = 1'b1;
    #1;
    // R1: reset state
    check("R1 rdata", rdata, 8'h00);
    check("R1 irq", {6'd0, irq_b, irq_a}, 8'h00);

    // R11/R2: sweep all write values with idle pins
    for (int w = 0; w < 256; w++) begin
      reg_write(8'(w));
      check("R11 R2 readback", rdata, 8'(w) & 8'h2D);
      check("R8 irq idle", {6'd0, irq_b, irq_a}, 8'h00);
    end
    sel = 1'b0; #1;
    check("R11 sel low", rdata, 8'h00);
    sel = 1'b1;

    // Every pin, polarity, enable and edge direction
    for (int c = 0; c < 2; c++)
      for (int pol = 0; pol < 2; pol++)
        for (int en = 0; en < 2; en++)
          for (int rise = 0; rise < 2; rise++) begin
            logic [7:0] cfg;
            logic       hit;
            logic [7:0] exp;
            cfg = cfg_of(c, pol[0], en[0]);
            hit = (rise == pol);
            reg_write(8'h00);
            set_pin(c, ~rise[0]);
            repeat (5) @(posedge clk);
            reg_write(cfg);
            check("R6 pre-clear", rdata, cfg);
            set_pin(c, rise[0]);
            @(posedge clk); @(posedge clk);
            @(negedge clk);
            check("R10 not yet", rdata, cfg);
            @(posedge clk);
            @(negedge clk);
            exp = hit ? (cfg | flag_bit(c)) : cfg;
            check(pol ? "R4 edge" : "R3 edge", rdata, exp);
            check("R9 other pin", rdata & flag_bit(1-c), 8'h00);
            check("R8 irq", {6'd0, irq_b, irq_a},
                  8'((hit & en[0]) << c));
            repeat (6) @(posedge clk);
            @(negedge clk);
            check("R5 hold", rdata, exp);
            reg_write(cfg | flag_bit(c));
            check("R5 write one", rdata, exp);
            reg_write(cfg);
            check("R6 clear", rdata, cfg);
            check("R8 irq after clear", {6'd0, irq_b, irq_a}, 8'h00);
          end

    // R7: edge and clear collide, per pin
    for (int c = 0; c < 2; c++) begin
      logic [7:0] cfg;
      cfg = cfg_of(c, 1'b1, 1'b1);
      reg_write(8'h00);
      set_pin(c, 1'b0);
      repeat (5) @(posedge clk);
      reg_write(cfg);
      @(negedge clk);
      set_pin(c, 1'b1);
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      sel = 1'b1; wr_en = 1'b1; wdata = cfg;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      #1;
      check("R7 edge wins", rdata, cfg | flag_bit(c));
      check("R7 R8 irq", {6'd0, irq_b, irq_a}, 8'(1 << c));
      reg_write(cfg);
      check("R7 later clear", rdata, cfg);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule